// File: doc/BRIEF.md
# Storage Command Transfer-Length Gate

This block sits in the command path of a block-storage front end. Ten-byte command descriptor blocks arrive one byte per cycle. A start marker flags the first byte of each command. The block keeps the operation code and the 16-bit big-endian transfer length. It then decides whether the command may go on to the media side.

The device buffer is 64 KiB and each block is 512 bytes, so no command may move more than 128 blocks. READ(10) and WRITE(10) commands that ask for more than that are rejected. A rejected command raises sense data reporting an illegal request with an invalid field in the descriptor. All other operation codes pass unchecked. The same limit is driven as a constant value, ready to be placed in the maximum-transfer-length field of a block-limits inquiry page.

Control is a three-state machine:
- IDLE waits for a start byte.
- COLLECT accepts bytes 1 to 9 and counts them.
- DECIDE lasts one cycle and issues the verdict.

The transitions are:
- IDLE to COLLECT on a start byte.
- COLLECT to COLLECT on every ordinary byte except the tenth; a start byte here restarts the count.
- COLLECT to DECIDE on the tenth byte.
- DECIDE to COLLECT when a start byte arrives in the verdict cycle; otherwise DECIDE to IDLE.

Top module: `xfer_len_gate`

## Requirements
- R1: During and after reset, until a command completes, verdict_valid, verdict_pass and sense_valid are 0, and sense_key, sense_asc and sense_ascq are 0.
- R2: verdict_valid is high for exactly the one cycle that follows the clock edge on which the tenth byte of a command was accepted.
- R3: Opcode 0x28 (READ(10)) or 0x2A (WRITE(10)) in byte 0 passes (verdict_pass = 1 with verdict_valid) when the length, formed as byte 7 (most significant) and byte 8 (least significant), is at most 128. This includes lengths 0 and 128.
- R4: A READ(10) or WRITE(10) whose length is 129 or more gives verdict_pass = 0. The whole 16-bit value is compared, so 0x0101 is rejected.
- R5: Any other opcode passes whatever its length bytes hold.
- R6: When sense_valid is 1, the outputs read sense_key = 0x5 (illegal request), sense_asc = 0x24 (invalid field in descriptor) and sense_ascq = 0x00. While sense_valid is 0, all three fields read 0.
- R7: sense_valid rises in the verdict cycle of a rejected command. It stays high until the first clock edge that accepts the start byte of a following command, and falls in the cycle after that edge.
- R8: A byte presented with cdb_valid low is ignored. A valid byte that arrives without cdb_sop while no command is being collected is also ignored.
- R9: A start byte accepted part-way through a command discards the partial command and begins a new one at byte 0.
- R10: max_xfer_len equals the buffer size divided by the block size, which is 128 with the default parameters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cdb_valid | input | 1 | cdb_byte carries a descriptor byte this cycle |
| cdb_sop | input | 1 | With cdb_valid, marks byte 0 of a command |
| cdb_byte | input | 8 | Descriptor byte |
| verdict_valid | output | 1 | One-cycle decision pulse |
| verdict_pass | output | 1 | Command may proceed (meaningful with verdict_valid) |
| sense_valid | output | 1 | Rejection sense data is held |
| sense_key | output | 4 | Sense key |
| sense_asc | output | 8 | Additional sense code |
| sense_ascq | output | 8 | Additional sense code qualifier |
| max_xfer_len | output | 32 | Block limit for the inquiry page |

## Verification
A miscounted byte index, whether it comes from a missed gap or a missed restart, would capture the wrong length bytes or issue the verdict on the wrong cycle. Either fault shows at verdict_valid or verdict_pass within the same command. A stuck or early-cleared sense register shows on sense_valid one cycle after the start byte of the next command. For that reason the reference model compares every output on every clock, through gaps, stray bytes, restarts and back-to-back commands.

// File: rtl/xlg_pkg.sv
package xlg_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_COLLECT = 2'd1,
        ST_DECIDE  = 2'd2
    } xlg_state_e;

    localparam logic [7:0] OPC_READ10  = 8'h28;
    localparam logic [7:0] OPC_WRITE10 = 8'h2A;

    localparam logic [3:0] SK_ILLEGAL_REQ  = 4'h5;
    localparam logic [7:0] ASC_BAD_FIELD   = 8'h24;
    localparam logic [7:0] ASCQ_BAD_FIELD  = 8'h00;

endpackage

// File: rtl/xlg_seq_fsm.sv
module xlg_seq_fsm
    import xlg_pkg::*;
#(
    parameter int CDB_LEN = 10,
    localparam int IDXW = $clog2(CDB_LEN)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cdb_valid,
    input  logic            cdb_sop,
    output logic            take,
    output logic [IDXW-1:0] take_idx,
    output logic            cmd_start,
    output logic            last_take,
    output logic            decide
);

    localparam logic [IDXW-1:0] LAST_IDX  = IDXW'(CDB_LEN - 1);
    localparam logic [IDXW-1:0] FIRST_IDX = IDXW'(1);

    xlg_state_e      state_q, state_d;
    logic [IDXW-1:0] idx_q, idx_d;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Byte index register (index of next expected byte)
    always_ff @(posedge clk) begin
        if (!rst_n) idx_q <= '0;
        else        idx_q <= idx_d;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        idx_d   = idx_q;
        unique case (state_q)
            ST_IDLE: begin
                if (cdb_valid && cdb_sop) begin
                    state_d = ST_COLLECT;
                    idx_d   = FIRST_IDX;
                end
            end
            ST_COLLECT: begin
                if (cdb_valid) begin
                    if (cdb_sop) begin
                        idx_d = FIRST_IDX;
                    end else if (idx_q == LAST_IDX) begin
                        state_d = ST_DECIDE;
                        idx_d   = '0;
                    end else begin
                        idx_d = idx_q + FIRST_IDX;
                    end
                end
            end
            ST_DECIDE: begin
                if (cdb_valid && cdb_sop) begin
                    state_d = ST_COLLECT;
                    idx_d   = FIRST_IDX;
                end else begin
                    state_d = ST_IDLE;
                end
            end
            default: begin
                state_d = ST_IDLE;
                idx_d   = '0;
            end
        endcase
    end

    // Output logic
    always_comb begin
        cmd_start = cdb_valid && cdb_sop;
        take      = cdb_valid && (cdb_sop || state_q == ST_COLLECT);
        take_idx  = cdb_sop ? '0 : idx_q;
        last_take = cdb_valid && !cdb_sop && (state_q == ST_COLLECT)
                    && (idx_q == LAST_IDX);
        decide    = (state_q == ST_DECIDE);
    end

endmodule

// File: rtl/xlg_field_capture.sv
module xlg_field_capture #(
    parameter int IDXW        = 4,
    parameter int OPC_IDX     = 0,
    parameter int LEN_MSB_IDX = 7,
    parameter int LEN_LSB_IDX = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            take,
    input  logic [IDXW-1:0] take_idx,
    input  logic [7:0]      cdb_byte,
    output logic [7:0]      opcode,
    output logic [15:0]     xfer_len
);

    localparam logic [IDXW-1:0] I_OPC = IDXW'(OPC_IDX);
    localparam logic [IDXW-1:0] I_MSB = IDXW'(LEN_MSB_IDX);
    localparam logic [IDXW-1:0] I_LSB = IDXW'(LEN_LSB_IDX);

    logic [7:0] opc_q, hi_q, lo_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            opc_q <= '0;
            hi_q  <= '0;
            lo_q  <= '0;
        end else if (take) begin
            if (take_idx == I_OPC) opc_q <= cdb_byte;
            if (take_idx == I_MSB) hi_q  <= cdb_byte;
            if (take_idx == I_LSB) lo_q  <= cdb_byte;
        end
    end

    assign opcode   = opc_q;
    assign xfer_len = {hi_q, lo_q};

endmodule

// File: rtl/xlg_len_judge.sv
module xlg_len_judge
    import xlg_pkg::*;
#(
    parameter int MAX_BLOCKS = 128
) (
    input  logic [7:0]  opcode,
    input  logic [15:0] xfer_len,
    output logic        allowed
);

    localparam logic [16:0] LIMIT = 17'(MAX_BLOCKS);

    logic is_rw;
    logic too_long;

    always_comb begin
        is_rw    = (opcode == OPC_READ10) || (opcode == OPC_WRITE10);
        too_long = {1'b0, xfer_len} > LIMIT;
        allowed  = !(is_rw && too_long);
    end

endmodule

// File: rtl/xlg_sense_hold.sv
module xlg_sense_hold
    import xlg_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       set_fail,
    input  logic       clear,
    output logic       sense_valid,
    output logic [3:0] sense_key,
    output logic [7:0] sense_asc,
    output logic [7:0] sense_ascq
);

    logic held_q;

    always_ff @(posedge clk) begin
        if (!rst_n)        held_q <= 1'b0;
        else if (set_fail) held_q <= 1'b1;
        else if (clear)    held_q <= 1'b0;
    end

    always_comb begin
        sense_valid = held_q;
        sense_key   = held_q ? SK_ILLEGAL_REQ : 4'h0;
        sense_asc   = held_q ? ASC_BAD_FIELD  : 8'h00;
        sense_ascq  = held_q ? ASCQ_BAD_FIELD : 8'h00;
    end

endmodule

// File: rtl/xfer_len_gate.sv
module xfer_len_gate #(
    parameter int BLOCK_BYTES  = 512,
    parameter int BUFFER_BYTES = 65536,
    parameter int CDB_LEN      = 10
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cdb_valid,
    input  logic        cdb_sop,
    input  logic [7:0]  cdb_byte,
    output logic        verdict_valid,
    output logic        verdict_pass,
    output logic        sense_valid,
    output logic [3:0]  sense_key,
    output logic [7:0]  sense_asc,
    output logic [7:0]  sense_ascq,
    output logic [31:0] max_xfer_len
);

    localparam int MAX_BLOCKS = BUFFER_BYTES / BLOCK_BYTES;
    localparam int IDXW       = $clog2(CDB_LEN);

    logic            take, cmd_start, last_take, decide, allowed;
    logic [IDXW-1:0] take_idx;
    logic [7:0]      opcode;
    logic [15:0]     xfer_len;

    xlg_seq_fsm #(.CDB_LEN(CDB_LEN)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .cdb_valid (cdb_valid),
        .cdb_sop   (cdb_sop),
        .take      (take),
        .take_idx  (take_idx),
        .cmd_start (cmd_start),
        .last_take (last_take),
        .decide    (decide)
    );

    xlg_field_capture #(
        .IDXW        (IDXW),
        .OPC_IDX     (0),
        .LEN_MSB_IDX (7),
        .LEN_LSB_IDX (8)
    ) u_cap (
        .clk      (clk),
        .rst_n    (rst_n),
        .take     (take),
        .take_idx (take_idx),
        .cdb_byte (cdb_byte),
        .opcode   (opcode),
        .xfer_len (xfer_len)
    );

    xlg_len_judge #(.MAX_BLOCKS(MAX_BLOCKS)) u_judge (
        .opcode   (opcode),
        .xfer_len (xfer_len),
        .allowed  (allowed)
    );

    xlg_sense_hold u_sense (
        .clk         (clk),
        .rst_n       (rst_n),
        .set_fail    (last_take && !allowed),
        .clear       (cmd_start),
        .sense_valid (sense_valid),
        .sense_key   (sense_key),
        .sense_asc   (sense_asc),
        .sense_ascq  (sense_ascq)
    );

    assign verdict_valid = decide;
    assign verdict_pass  = decide && allowed;
    assign max_xfer_len  = 32'(MAX_BLOCKS);

endmodule

// File: rtl/xfer_len_gate_chk.sv
module xfer_len_gate_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cdb_valid,
    input logic       cdb_sop,
    input logic       verdict_valid,
    input logic       verdict_pass,
    input logic       sense_valid,
    input logic [3:0] sense_key,
    input logic [7:0] sense_asc,
    input logic [7:0] sense_ascq
);

    assert_pulse_one_cycle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        verdict_valid |=> !verdict_valid);

    assert_pass_needs_valid_R3: assert property (@(posedge clk) disable iff (!rst_n)
        verdict_pass |-> verdict_valid);

    assert_pass_no_sense_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (verdict_valid && verdict_pass) |-> !sense_valid);

    assert_fail_has_sense_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (verdict_valid && !verdict_pass) |-> sense_valid);

    assert_sense_codes_R6: assert property (@(posedge clk) disable iff (!rst_n)
        sense_valid |-> (sense_key == 4'h5 && sense_asc == 8'h24 && sense_ascq == 8'h00));

    assert_sense_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !sense_valid |-> (sense_key == 4'h0 && sense_asc == 8'h00 && sense_ascq == 8'h00));

    assert_sense_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (sense_valid && !(cdb_valid && cdb_sop)) |=> sense_valid);

    assert_sense_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sense_valid) |-> (verdict_valid && !verdict_pass));

endmodule

bind xfer_len_gate xfer_len_gate_chk chk_i (.*);

// File: tb/xfer_len_gate_tb_top.sv
module xfer_len_gate_tb_top;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cdb_valid, cdb_sop;
    logic [7:0]  cdb_byte;
    logic        verdict_valid, verdict_pass, sense_valid;
    logic [3:0]  sense_key;
    logic [7:0]  sense_asc, sense_ascq;
    logic [31:0] max_xfer_len;

    always #2 clk = ~clk;

    xfer_len_gate dut_i (.*);

    int    vectors = 0;
    int    miscompares = 0;
    bit    finished = 0;
    string cur_tag = "R3";

    // reference model state
    logic [7:0] q[$];
    bit exp_vv = 0, exp_pass = 0, exp_sv = 0;

    task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s %s actual=%0h expected=%0h t=%0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic model(bit v, bit s, logic [7:0] b);
        int len;
        bit rw;
        exp_vv = 0;
        if (v && s) begin
            q.delete();
            q.push_back(b);
            exp_sv = 0;
        end else if (v && q.size() > 0) begin
            q.push_back(b);
            if (q.size() == 10) begin
                len = {q[7], q[8]};
                rw = (q[0] == 8'h28) || (q[0] == 8'h2A);
                exp_vv = 1;
                exp_pass = !(rw && len > 128);
                if (!exp_pass) exp_sv = 1;
                q.delete();
            end
        end
    endtask

    task automatic compare_all();
        chk("R2", "verdict_valid", 32'(verdict_valid), 32'(exp_vv));
        chk(cur_tag, "verdict_pass", 32'(verdict_pass), 32'(exp_vv && exp_pass));
        chk("R7", "sense_valid", 32'(sense_valid), 32'(exp_sv));
        chk("R6", "sense_key", 32'(sense_key), exp_sv ? 32'h5 : 32'h0);
        chk("R6", "sense_asc", 32'(sense_asc), exp_sv ? 32'h24 : 32'h0);
        chk("R6", "sense_ascq", 32'(sense_ascq), 32'h0);
        chk("R10", "max_xfer_len", max_xfer_len, 32'd128);
    endtask

    task automatic step(bit v, bit s, logic [7:0] b);
        @(negedge clk);
        cdb_valid = v; cdb_sop = s; cdb_byte = b;
        model(v, s, b);
        @(posedge clk);
        #1;
        compare_all();
    endtask

    task automatic send_cmd(logic [7:0] op, logic [15:0] len, int max_gap, int nbytes = 10);
        for (int i = 0; i < nbytes; i++) begin
            logic [7:0] val;
            if (i == 0)      val = op;
            else if (i == 7) val = len[15:8];
            else if (i == 8) val = len[7:0];
            else             val = 8'h40 + 8'(i);
            if (max_gap > 0) begin
                int g = $urandom_range(max_gap, 0);
                for (int k = 0; k < g; k++) step(1'b0, 1'($urandom), 8'($urandom)); // R8 gaps
            end
            step(1'b1, (i == 0), val);
        end
    endtask

    task automatic idle(int n);
        for (int k = 0; k < n; k++) step(1'b0, 1'b0, 8'h00);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        rst_n = 0; cdb_valid = 0; cdb_sop = 0; cdb_byte = 0;
        repeat (3) @(posedge clk);
        #1;
        // R1 reset state
        chk("R1", "verdict_valid", 32'(verdict_valid), 0);
        chk("R1", "verdict_pass", 32'(verdict_pass), 0);
        chk("R1", "sense_valid", 32'(sense_valid), 0);
        chk("R1", "sense_key", 32'(sense_key), 0);
        @(negedge clk); rst_n = 1;
        idle(2);

        // R3: in-range READ/WRITE including 0 and 128
        cur_tag = "R3";
        send_cmd(8'h28, 16'd0, 0);     idle(2);
        send_cmd(8'h28, 16'd1, 0);     idle(1);
        send_cmd(8'h28, 16'd128, 0);   idle(1);
        send_cmd(8'h2A, 16'd128, 0);
        send_cmd(8'h2A, 16'd100, 0);   idle(2);

        // R4: over limit, incl. high-byte-only check
        cur_tag = "R4";
        send_cmd(8'h28, 16'd129, 0);   idle(3);
        send_cmd(8'h2A, 16'd256, 0);   idle(1);
        send_cmd(8'h2A, 16'hFFFF, 0);
        send_cmd(8'h28, 16'h0101, 0);  idle(1);
        // R7: pass after fail clears sense on start byte
        cur_tag = "R7";
        send_cmd(8'h2A, 16'd8, 0);     idle(2);

        // R5: other opcodes unchecked
        cur_tag = "R5";
        send_cmd(8'h2A, 16'd300, 0);
        send_cmd(8'h12, 16'hFFFF, 0);
        send_cmd(8'h2F, 16'd500, 0);
        send_cmd(8'h08, 16'd255, 0);   idle(2);

        // R8: gaps and stray bytes while idle
        cur_tag = "R8";
        for (int k = 0; k < 4; k++) step(1'b1, 1'b0, 8'h2A);
        send_cmd(8'h28, 16'd200, 3);
        for (int k = 0; k < 3; k++) step(1'b1, 1'b0, 8'h28);
        send_cmd(8'h2A, 16'd64, 4);    idle(2);

        // R9: restart mid-command
        cur_tag = "R9";
        send_cmd(8'h28, 16'd900, 0, 8);
        send_cmd(8'h28, 16'd16, 0);    idle(1);
        send_cmd(8'h12, 16'd0, 0, 5);
        send_cmd(8'h2A, 16'd129, 1);   idle(2);

        // random mix
        cur_tag = "R4";
        for (int n = 0; n < 400; n++) begin
            logic [7:0] op;
            logic [15:0] ln;
            int pick = $urandom_range(3, 0);
            op = (pick == 0) ? 8'h28 : (pick == 1) ? 8'h2A : 8'($urandom);
            ln = ($urandom_range(1, 0) == 1) ? 16'($urandom_range(260, 0)) : 16'($urandom);
            send_cmd(op, ln, $urandom_range(2, 0), ($urandom_range(9, 0) == 0) ? 6 : 10);
            if ($urandom_range(1, 0) == 1) idle($urandom_range(2, 0));
        end
        idle(3);
        finish_run();
    end

endmodule